// File: doc/BRIEF.md
# PHY Context Save and Restore Sequencer

This block keeps a serial PHY's configuration across a deep system suspend in which the PHY's own state is lost. Before the suspend, a save request makes the sequencer read a fixed list of PHY registers over a register master port. It then reads a fixed list of link attributes over an attribute access port. All values go into a flip-flop snapshot buffer with one entry per list element. On resume, a restore request replays the PHY bring-up: soft reset, a reset settle delay, power-up, register write-back, reset release, start, attribute write-back, and a ready poll with a timeout. This avoids a full link re-initialisation.

A full-initialisation mode runs the same bring-up. In that mode a fixed calibration table is written instead of the register snapshot, and the attribute write-back is skipped. Saving is gated by a feature enable and the link's hibernate state. Restoring is further gated by a system-suspended flag, which a pulse on `susp_mark` sets and a successful restore clears.

The FSM states are:

- `ST_IDLE`
- `ST_SV_REG`: register reads during save.
- `ST_SV_ATT`: attribute reads during save.
- `ST_RST_WAIT`: reset settle delay.
- `ST_PWR_UP`
- `ST_REG_WB`: register or calibration write-back.
- `ST_START`
- `ST_ATT_WB`: attribute write-back.
- `ST_POLL_RD`
- `ST_POLL_WT`

The transitions are:

- `ST_IDLE` → `ST_SV_REG`: on an accepted save.
- `ST_IDLE` → `ST_RST_WAIT`: on an accepted restore or full init.
- `ST_SV_REG` → `ST_SV_ATT`: after the last register read.
- `ST_SV_ATT` → `ST_IDLE`: after the last attribute read.
- `ST_RST_WAIT` → `ST_PWR_UP`: after the delay.
- `ST_PWR_UP` → `ST_REG_WB`.
- `ST_REG_WB` → `ST_START`: after the last write.
- `ST_START` → `ST_ATT_WB` in restore mode, or `ST_START` → `ST_POLL_RD` in full mode.
- `ST_ATT_WB` → `ST_POLL_RD`: after the last attribute write.
- `ST_POLL_RD` → `ST_IDLE`: on ready or timeout.
- `ST_POLL_RD` → `ST_POLL_WT`: when not ready.
- `ST_POLL_WT` → `ST_POLL_RD`: after the poll interval.

Top module: `phy_ctx_keeper`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `busy_err`, `susp_flag`, `phy_soft_rst` and all three access strobes are low.
- R2: A save request with `feat_en` low or `link_hib` low makes no access and raises `done` (with `fail` low) one cycle after the request edge.
- R3: An accepted save reads every listed register in list order, one `reg_rd` per cycle. It then handles each listed attribute in list order with two attribute strobes: `att_ctrl`=0x11 (read both lanes, value taken from `att_rdata`) and then 0x00 (clear). `done` follows one cycle after the last strobe. At most one of `reg_wr`, `reg_rd` and `att_stb` is high in any cycle.
- R4: A restore request (`init_mode`=1) runs only when `feat_en`, `link_hib` and `susp_flag` are all high. Otherwise it makes no access and raises `done` one cycle after the request edge. `susp_flag` is set by a `susp_mark` pulse and is cleared only by a restore that completes without error.
- R5: A running restore raises `phy_soft_rst` and holds it for RST_CYC cycles with no access. It then writes 0x01 to the power-up register and writes each saved register value back to its address in list order, all with `phy_soft_rst` high. Next it lowers `phy_soft_rst` and writes 0x01 to the start register. The power-up write comes exactly RST_CYC cycles after `phy_soft_rst` rises.
- R6: After the start write, each saved attribute is written back in list order with its identifier on `att_id` and its saved value on `att_wdata`. This takes three strobes: 0x22 (write both lanes), then 0x44 (TX update) when the identifier is below RX_BASE or 0x88 (RX update) otherwise, then 0x00.
- R7: The ready poll reads the status register and tests bit 0, with successive reads exactly POLL_CYC cycles apart. On the first read with bit 0 set, `done` rises one cycle later with `fail` low.
- R8: A poll read that finds bit 0 clear once TMO_CYC or more cycles have passed since the first poll read ends the run. `done` and `fail` rise one cycle later, so ceil(TMO_CYC/POLL_CYC)+1 reads occur, and `susp_flag` stays set.
- R9: A full-initialisation request (`init_mode`=0) always runs, whatever the gating inputs. It writes the calibration table (address/value pairs in table order) in place of the saved registers, skips the attribute write-back, and leaves `susp_flag` unchanged.
- R10: An `init_mode` of 2 or 3 makes no access and raises `done` and `fail` together one cycle after the request edge.
- R11: A save or restore request while `busy` is high has no effect on the running sequence and sets `busy_err`, which then stays high until reset.
- R12: If save and restore are requested in the same idle cycle, only the save is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_en | input | 1 | Save/restore feature enable |
| link_hib | input | 1 | Link is in the hibernate state |
| susp_mark | input | 1 | Pulse: system suspend completed, sets the flag |
| save_req | input | 1 | Pulse: take a snapshot |
| restore_req | input | 1 | Pulse: run a bring-up of type `init_mode` |
| init_mode | input | 2 | 0 full init, 1 snapshot restore, others invalid |
| reg_wr | output | 1 | Register write strobe |
| reg_rd | output | 1 | Register read strobe |
| reg_addr | output | AW | Register address |
| reg_wdata | output | DW | Register write data |
| reg_rdata | input | DW | Register read data, valid in the strobe cycle |
| att_stb | output | 1 | Attribute control strobe |
| att_ctrl | output | 8 | Attribute control byte (lane 0 bits 3:0, lane 1 bits 7:4) |
| att_id | output | 16 | Attribute identifier |
| att_wdata | output | DW | Attribute write value |
| att_rdata | input | DW | Attribute read value, valid in the strobe cycle |
| phy_soft_rst | output | 1 | PHY soft reset |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Error, valid with `done` |
| busy_err | output | 1 | Sticky: request arrived while busy |
| susp_flag | output | 1 | System-suspended flag |

## Verification
Every access strobe is combinational from the state, so each expected access is compared with the design's ports in the very cycle it appears. Skipped, invalid and rejected requests must show `done` one cycle after the request edge. Completed sequences must show `done` one cycle after their last access. The bench tracks this with a per-cycle countdown that demands `done` exactly then and nowhere else. The power-up write is timed against the rise of `phy_soft_rst` (RST_CYC cycles later), and successive status reads are timed against each other (POLL_CYC cycles apart). Flag and error outputs are read at the ports between runs.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SV_REG,
        ST_SV_ATT,
        ST_RST_WAIT,
        ST_PWR_UP,
        ST_REG_WB,
        ST_START,
        ST_ATT_WB,
        ST_POLL_RD,
        ST_POLL_WT
    } ctx_state_e;

    localparam logic [1:0] MODE_FULL    = 2'd0;
    localparam logic [1:0] MODE_RESTORE = 2'd1;

    // attribute control byte: lane 0 in bits 3:0, lane 1 in bits 7:4
    localparam logic [7:0] CTL_RD  = 8'h11;
    localparam logic [7:0] CTL_WR  = 8'h22;
    localparam logic [7:0] CTL_TXU = 8'h44;
    localparam logic [7:0] CTL_RXU = 8'h88;
    localparam logic [7:0] CTL_CLR = 8'h00;

endpackage

// File: rtl/ctx_timer.sv
module ctx_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ctx_snap.sv
module ctx_snap #(
    parameter int N  = 8,
    parameter int DW = 32,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] widx,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] ridx,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] ent [N];

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (we && widx == SW'(g))
                q <= wdata;
        end
        assign ent[g] = q;
    end

    assign rdata = ent[ridx];

endmodule

// File: rtl/phy_ctx_keeper.sv
module phy_ctx_keeper
    import ctx_pkg::*;
#(
    parameter int CLK_HZ  = 100_000_000,
    parameter int RST_US  = 1000,
    parameter int POLL_US = 10,
    parameter int TMO_US  = 1_000_000,
    parameter int AW      = 12,
    parameter int DW      = 32,
    parameter int N_REG   = 4,
    parameter int N_ATT   = 4,
    parameter int N_CAL   = 3,
    parameter logic [N_REG-1:0][AW-1:0] REG_LIST = {12'h04C, 12'h030, 12'h020, 12'h010},
    parameter logic [N_ATT-1:0][15:0]   ATT_LIST = {16'h00A7, 16'h00A1, 16'h002C, 16'h0023},
    parameter logic [N_CAL-1:0][AW-1:0] CAL_ADDR = {12'h018, 12'h014, 12'h010},
    parameter logic [N_CAL-1:0][DW-1:0] CAL_DATA = {32'h0000_0C5A, 32'h0000_0033, 32'h0000_0081},
    parameter logic [AW-1:0] PWR_ADDR   = 12'h0B4,
    parameter logic [AW-1:0] START_ADDR = 12'h0B0,
    parameter logic [AW-1:0] STAT_ADDR  = 12'h174,
    parameter logic [15:0]   RX_BASE    = 16'h00A1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          feat_en,
    input  logic          link_hib,
    input  logic          susp_mark,
    input  logic          save_req,
    input  logic          restore_req,
    input  logic [1:0]    init_mode,
    output logic          reg_wr,
    output logic          reg_rd,
    output logic [AW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    input  logic [DW-1:0] reg_rdata,
    output logic          att_stb,
    output logic [7:0]    att_ctrl,
    output logic [15:0]   att_id,
    output logic [DW-1:0] att_wdata,
    input  logic [DW-1:0] att_rdata,
    output logic          phy_soft_rst,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic          busy_err,
    output logic          susp_flag
);

    localparam int CPU      = CLK_HZ / 1_000_000;
    localparam int RST_CYC  = CPU * RST_US;
    localparam int POLL_CYC = CPU * POLL_US;
    localparam int TMO_CYC  = CPU * TMO_US;
    localparam int STEP_MAX = (RST_CYC > POLL_CYC) ? RST_CYC : POLL_CYC;
    localparam int STW      = $clog2(STEP_MAX) + 1;
    localparam int TMW      = $clog2(TMO_CYC + POLL_CYC) + 1;
    localparam int N_SNAP   = N_REG + N_ATT;
    localparam int SW       = $clog2(N_SNAP);
    localparam int NM1      = (N_REG > N_ATT) ? N_REG : N_ATT;
    localparam int NMAX     = (NM1 > N_CAL) ? NM1 : N_CAL;
    localparam int IW       = $clog2(NMAX);
    localparam int RW       = $clog2(N_REG);
    localparam int TW       = $clog2(N_ATT);
    localparam int CW       = $clog2(N_CAL);

    ctx_state_e    state, nxt;
    logic [IW-1:0] idx;
    logic [1:0]    sub;
    logic          full_q;
    logic          done_q, fail_q, berr_q, flag_q;
    logic [STW-1:0] stp_cnt;
    logic [TMW-1:0] tmo_cnt;
    logic          save_ok, rest_ok, ready, tmo_hit;
    logic [IW-1:0] wb_last;

    logic          snap_we;
    logic [SW-1:0] snap_widx, snap_ridx;
    logic [DW-1:0] snap_wdata, snap_rdata;

    assign save_ok = feat_en && link_hib;
    assign rest_ok = feat_en && link_hib && flag_q;
    assign ready   = reg_rdata[0];
    assign tmo_hit = tmo_cnt >= TMW'(TMO_CYC);
    assign wb_last = full_q ? IW'(N_CAL - 1) : IW'(N_REG - 1);

    ctx_timer #(.W(STW)) u_step (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state != nxt),
        .cnt  (stp_cnt)
    );

    ctx_timer #(.W(TMW)) u_tmo (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!(state == ST_POLL_RD || state == ST_POLL_WT)),
        .cnt  (tmo_cnt)
    );

    ctx_snap #(.N(N_SNAP), .DW(DW)) u_snap (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (snap_we),
        .widx (snap_widx),
        .wdata(snap_wdata),
        .ridx (snap_ridx),
        .rdata(snap_rdata)
    );

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (save_req) begin
                    if (save_ok) nxt = ST_SV_REG;
                end else if (restore_req) begin
                    if (init_mode == MODE_FULL ||
                        (init_mode == MODE_RESTORE && rest_ok))
                        nxt = ST_RST_WAIT;
                end
            end
            ST_SV_REG:   if (idx == IW'(N_REG - 1)) nxt = ST_SV_ATT;
            ST_SV_ATT:   if (sub == 2'd1 && idx == IW'(N_ATT - 1)) nxt = ST_IDLE;
            ST_RST_WAIT: if (stp_cnt == STW'(RST_CYC - 1)) nxt = ST_PWR_UP;
            ST_PWR_UP:   nxt = ST_REG_WB;
            ST_REG_WB:   if (idx == wb_last) nxt = ST_START;
            ST_START:    nxt = full_q ? ST_POLL_RD : ST_ATT_WB;
            ST_ATT_WB:   if (sub == 2'd2 && idx == IW'(N_ATT - 1)) nxt = ST_POLL_RD;
            ST_POLL_RD:  nxt = (ready || tmo_hit) ? ST_IDLE : ST_POLL_WT;
            ST_POLL_WT:  if (stp_cnt == STW'(POLL_CYC - 2)) nxt = ST_POLL_RD;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register and sequence bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            sub    <= '0;
            full_q <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            berr_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            state  <= nxt;
            done_q <= 1'b0;
            fail_q <= 1'b0;

            if (state != nxt) begin
                idx <= '0;
                sub <= '0;
            end else begin
                unique case (state)
                    ST_SV_REG, ST_REG_WB: idx <= idx + 1'b1;
                    ST_SV_ATT: begin
                        if (sub == 2'd1) begin
                            sub <= '0;
                            idx <= idx + 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    ST_ATT_WB: begin
                        if (sub == 2'd2) begin
                            sub <= '0;
                            idx <= idx + 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end

            if (state == ST_IDLE && nxt == ST_RST_WAIT)
                full_q <= (init_mode == MODE_FULL);

            if (state == ST_IDLE) begin
                if (save_req) begin
                    if (!save_ok) done_q <= 1'b1;
                end else if (restore_req) begin
                    if (init_mode != MODE_FULL && init_mode != MODE_RESTORE) begin
                        done_q <= 1'b1;
                        fail_q <= 1'b1;
                    end else if (init_mode == MODE_RESTORE && !rest_ok) begin
                        done_q <= 1'b1;
                    end
                end
            end else if (save_req || restore_req) begin
                berr_q <= 1'b1;
            end

            if (state == ST_SV_ATT && nxt == ST_IDLE)
                done_q <= 1'b1;

            if (state == ST_POLL_RD) begin
                if (ready) begin
                    done_q <= 1'b1;
                    if (!full_q) flag_q <= 1'b0;
                end else if (tmo_hit) begin
                    done_q <= 1'b1;
                    fail_q <= 1'b1;
                end
            end

            if (susp_mark)
                flag_q <= 1'b1;
        end
    end

    // outputs from the current state
    always_comb begin
        reg_wr       = 1'b0;
        reg_rd       = 1'b0;
        reg_addr     = '0;
        reg_wdata    = '0;
        att_stb      = 1'b0;
        att_ctrl     = CTL_CLR;
        att_id       = '0;
        att_wdata    = '0;
        phy_soft_rst = 1'b0;
        snap_we      = 1'b0;
        snap_widx    = SW'(idx[RW-1:0]);
        snap_wdata   = reg_rdata;
        snap_ridx    = SW'(idx[RW-1:0]);
        unique case (state)
            ST_IDLE: ;
            ST_SV_REG: begin
                reg_rd   = 1'b1;
                reg_addr = REG_LIST[idx[RW-1:0]];
                snap_we  = 1'b1;
            end
            ST_SV_ATT: begin
                att_stb    = 1'b1;
                att_id     = ATT_LIST[idx[TW-1:0]];
                att_ctrl   = (sub == 2'd0) ? CTL_RD : CTL_CLR;
                snap_we    = (sub == 2'd0);
                snap_widx  = SW'(N_REG) + SW'(idx[TW-1:0]);
                snap_wdata = att_rdata;
            end
            ST_RST_WAIT: phy_soft_rst = 1'b1;
            ST_PWR_UP: begin
                phy_soft_rst = 1'b1;
                reg_wr       = 1'b1;
                reg_addr     = PWR_ADDR;
                reg_wdata    = DW'(1);
            end
            ST_REG_WB: begin
                phy_soft_rst = 1'b1;
                reg_wr       = 1'b1;
                if (full_q) begin
                    reg_addr  = CAL_ADDR[idx[CW-1:0]];
                    reg_wdata = CAL_DATA[idx[CW-1:0]];
                end else begin
                    reg_addr  = REG_LIST[idx[RW-1:0]];
                    reg_wdata = snap_rdata;
                end
            end
            ST_START: begin
                reg_wr    = 1'b1;
                reg_addr  = START_ADDR;
                reg_wdata = DW'(1);
            end
            ST_ATT_WB: begin
                att_stb   = 1'b1;
                att_id    = ATT_LIST[idx[TW-1:0]];
                snap_ridx = SW'(N_REG) + SW'(idx[TW-1:0]);
                att_wdata = snap_rdata;
                if (sub == 2'd0)
                    att_ctrl = CTL_WR;
                else if (sub == 2'd1)
                    att_ctrl = (att_id < RX_BASE) ? CTL_TXU : CTL_RXU;
                else
                    att_ctrl = CTL_CLR;
            end
            ST_POLL_RD: begin
                reg_rd   = 1'b1;
                reg_addr = STAT_ADDR;
            end
            ST_POLL_WT: ;
            default: ;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign done      = done_q;
    assign fail      = fail_q;
    assign busy_err  = berr_q;
    assign susp_flag = flag_q;

    // R3: one access per cycle
    a_r3_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd, att_stb}));

    // R5: power-up write happens under reset, start write after release
    a_r5_pwr_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == PWR_ADDR) |-> phy_soft_rst);

    a_r5_start_released: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == START_ADDR) |-> !phy_soft_rst);

    // R4: the flag only drops together with a clean completion
    a_r4_flag_clear_ok: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(susp_flag) |-> (done && !fail));

    // R10: an error is always reported with completion
    a_r10_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    // R11: busy error is sticky
    a_r11_busy_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |=> busy_err);

endmodule

// File: tb/phy_ctx_keeper_bench.sv
module phy_ctx_keeper_bench;

    localparam int RST_CYC  = 20;
    localparam int POLL_CYC = 4;
    localparam int TMO_CYC  = 100;
    localparam logic [3:0][11:0] B_REG  = {12'h04C, 12'h030, 12'h020, 12'h010};
    localparam logic [3:0][15:0] B_ATT  = {16'h00A7, 16'h00A1, 16'h002C, 16'h0023};
    localparam logic [2:0][11:0] B_CALA = {12'h018, 12'h014, 12'h010};
    localparam logic [2:0][31:0] B_CALD = {32'h0000_0C5A, 32'h0000_0033, 32'h0000_0081};
    localparam logic [11:0] B_PWR  = 12'h0B4;
    localparam logic [11:0] B_STRT = 12'h0B0;
    localparam logic [11:0] B_STAT = 12'h174;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic feat_en = 0, link_hib = 0, susp_mark = 0, save_req = 0, restore_req = 0;
    logic [1:0] init_mode = 2'd0;
    logic reg_wr, reg_rd, att_stb, phy_soft_rst, busy, done, fail, busy_err, susp_flag;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata, att_wdata, att_rdata;
    logic [7:0]  att_ctrl;
    logic [15:0] att_id;

    always #5 clk = ~clk;

    phy_ctx_keeper #(
        .CLK_HZ(1_000_000), .RST_US(RST_CYC), .POLL_US(POLL_CYC), .TMO_US(TMO_CYC),
        .AW(12), .DW(32), .N_REG(4), .N_ATT(4), .N_CAL(3),
        .REG_LIST(B_REG), .ATT_LIST(B_ATT), .CAL_ADDR(B_CALA), .CAL_DATA(B_CALD),
        .PWR_ADDR(B_PWR), .START_ADDR(B_STRT), .STAT_ADDR(B_STAT), .RX_BASE(16'h00A1)
    ) u_phy_ctx_keeper (
        .clk(clk), .rst_n(rst_n), .feat_en(feat_en), .link_hib(link_hib),
        .susp_mark(susp_mark), .save_req(save_req), .restore_req(restore_req),
        .init_mode(init_mode), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .att_stb(att_stb),
        .att_ctrl(att_ctrl), .att_id(att_id), .att_wdata(att_wdata),
        .att_rdata(att_rdata), .phy_soft_rst(phy_soft_rst), .busy(busy),
        .done(done), .fail(fail), .busy_err(busy_err), .susp_flag(susp_flag)
    );

    // ---------------- PHY model ----------------
    int gen = 1;
    int reads_seen = 0;
    int rd_base = 0;
    int ready_after = 0;
    bit ready_never = 0;

    function automatic logic [31:0] regval(logic [11:0] a, int g);
        return 32'(g) * 32'h0101_0000 + {20'h0, a};
    endfunction
    function automatic logic [31:0] attval(logic [15:0] id, int g);
        return 32'hC000_0000 + 32'(g) * 32'h100 + {16'h0, id};
    endfunction

    assign reg_rdata = (reg_addr == B_STAT)
        ? {31'b0, (!ready_never && (reads_seen - rd_base) >= ready_after)}
        : regval(reg_addr, gen);
    assign att_rdata = attval(att_id, gen);

    always @(posedge clk)
        if (reg_rd && reg_addr == B_STAT) reads_seen <= reads_seen + 1;

    // ---------------- reference model ----------------
    typedef struct {
        int          kind;   // 0 reg write, 1 reg read, 2 attribute strobe
        logic [15:0] addr;
        logic [7:0]  ctrl;
        logic [31:0] data;
        bit          chkd;
        bit          rst;
        string       req;
    } item_t;

    item_t q[$];
    logic [31:0] sv_reg [4];
    logic [31:0] sv_att [4];

    int nchk = 0, nfail = 0;
    int dcnt = 0, done_seen = 0, cyc = 0, t_rise = 0, last_rd = 0;
    bit have_rd = 0, long_seq = 0, exp_fail = 0, rst_prev = 0;
    string cur_req = "R1";

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(int k, logic [15:0] a, logic [7:0] c, logic [31:0] d,
                        bit cd, bit r, string req);
        item_t it;
        it.kind = k; it.addr = a; it.ctrl = c; it.data = d;
        it.chkd = cd; it.rst = r; it.req = req;
        q.push_back(it);
    endtask

    task automatic exp_save();
        for (int i = 0; i < 4; i++) begin
            push(1, {4'h0, B_REG[i]}, 8'h00, 32'h0, 0, 0, "R3");
            sv_reg[i] = regval(B_REG[i], gen);
        end
        for (int i = 0; i < 4; i++) begin
            push(2, B_ATT[i], 8'h11, 32'h0, 0, 0, "R3");
            push(2, B_ATT[i], 8'h00, 32'h0, 0, 0, "R3");
            sv_att[i] = attval(B_ATT[i], gen);
        end
    endtask

    task automatic exp_restore(bit full, int nreads, string preq);
        push(0, {4'h0, B_PWR}, 8'h00, 32'h1, 1, 1, "R5");
        if (full) begin
            for (int i = 0; i < 3; i++)
                push(0, {4'h0, B_CALA[i]}, 8'h00, B_CALD[i], 1, 1, "R9");
        end else begin
            for (int i = 0; i < 4; i++)
                push(0, {4'h0, B_REG[i]}, 8'h00, sv_reg[i], 1, 1, "R5");
        end
        push(0, {4'h0, B_STRT}, 8'h00, 32'h1, 1, 0, "R5");
        if (!full) begin
            for (int i = 0; i < 4; i++) begin
                push(2, B_ATT[i], 8'h22, sv_att[i], 1, 0, "R6");
                push(2, B_ATT[i], (B_ATT[i] < 16'h00A1) ? 8'h44 : 8'h88, 32'h0, 0, 0, "R6");
                push(2, B_ATT[i], 8'h00, 32'h0, 0, 0, "R6");
            end
        end
        for (int i = 0; i < nreads; i++)
            push(1, {4'h0, B_STAT}, 8'h00, 32'h0, 0, 0, preq);
    endtask

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n) begin
            item_t it;
            int n;
            cyc++;
            if (phy_soft_rst && !rst_prev) t_rise = cyc;
            rst_prev = phy_soft_rst;

            if (dcnt > 0) begin
                dcnt--;
                if (dcnt == 0) begin
                    chk(cur_req, "done", done, 1);
                    chk(cur_req, "fail", fail, exp_fail);
                    done_seen++;
                end else if (done) begin
                    chk(cur_req, "early done", done, 0);
                end
            end else if (done) begin
                chk(cur_req, "unexpected done", done, 0);
            end

            n = int'(reg_wr) + int'(reg_rd) + int'(att_stb);
            if (n > 1) chk("R3", "strobes in one cycle", n, 1);
            if (n >= 1) begin
                if (q.size() == 0) begin
                    chk(cur_req, "unexpected access", 1, 0);
                end else begin
                    it = q.pop_front();
                    chk(it.req, "access kind", reg_wr ? 0 : (reg_rd ? 1 : 2), it.kind);
                    chk(it.req, "address/id", att_stb ? att_id : {4'h0, reg_addr}, it.addr);
                    chk(it.req, "soft reset level", phy_soft_rst, it.rst);
                    if (att_stb) chk(it.req, "attr ctrl", att_ctrl, it.ctrl);
                    if (it.chkd) chk(it.req, "write value", att_stb ? att_wdata : reg_wdata, it.data);
                    if (reg_wr && reg_addr == B_PWR)
                        chk("R5", "reset hold cycles", cyc - t_rise, RST_CYC);
                    if (reg_rd && reg_addr == B_STAT) begin
                        if (have_rd) chk("R7", "poll spacing", cyc - last_rd, POLL_CYC);
                        last_rd = cyc;
                        have_rd = 1;
                    end
                    if (q.size() == 0 && long_seq) begin
                        dcnt = 1;
                        long_seq = 0;
                    end
                end
            end
        end
    end

    task automatic run(bit sv, bit rs, logic [1:0] md, bit longs, bit efail,
                       string req, bit inject);
        int n0;
        n0 = done_seen;
        @(posedge clk); #2;
        cur_req = req; exp_fail = efail; long_seq = longs; have_rd = 0;
        rd_base = reads_seen;
        if (!longs) dcnt = 2;
        save_req = sv; restore_req = rs; init_mode = md;
        @(posedge clk); #2;
        save_req = 0; restore_req = 0;
        if (inject) begin
            repeat (3) @(posedge clk);
            #2 save_req = 1; restore_req = 1; init_mode = 2'd1;
            @(posedge clk); #2;
            save_req = 0; restore_req = 0;
        end
        while (done_seen == n0) @(negedge clk);
        @(posedge clk); #2;
    endtask

    task automatic mark();
        @(posedge clk); #2 susp_mark = 1;
        @(posedge clk); #2 susp_mark = 0;
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "fail", fail, 0);
        chk("R1", "busy_err", busy_err, 0);
        chk("R1", "susp_flag", susp_flag, 0);
        chk("R1", "soft reset", phy_soft_rst, 0);
        chk("R1", "strobes", {reg_wr, reg_rd, att_stb}, 0);
        rst_n = 1;

        // R2: save refused when link not in hibernate
        feat_en = 1; link_hib = 0;
        run(1, 0, 2'd1, 0, 0, "R2", 0);

        // R3: snapshot
        link_hib = 1; gen = 1;
        exp_save();
        run(1, 0, 2'd1, 1, 0, "R3", 0);
        gen = 2;

        // R4: restore refused without suspend flag
        run(0, 1, 2'd1, 0, 0, "R4", 0);
        mark();
        chk("R4", "flag set by mark", susp_flag, 1);
        chk("R11", "busy_err before", busy_err, 0);

        // R5/R6/R7 restore with immediate ready, plus a request while busy (R11)
        ready_never = 0; ready_after = 0;
        exp_restore(0, 1, "R7");
        run(0, 1, 2'd1, 1, 0, "R5", 1);
        chk("R4", "flag cleared after restore", susp_flag, 0);
        chk("R11", "busy_err sticky", busy_err, 1);

        // R7: ready on third poll
        mark();
        ready_after = 2;
        exp_restore(0, 3, "R7");
        run(0, 1, 2'd1, 1, 0, "R7", 0);
        chk("R7", "flag cleared", susp_flag, 0);

        // R8: timeout
        mark();
        ready_never = 1;
        exp_restore(0, (TMO_CYC + POLL_CYC - 1) / POLL_CYC + 1, "R8");
        run(0, 1, 2'd1, 1, 1, "R8", 0);
        chk("R8", "flag kept after timeout", susp_flag, 1);

        // R9: full init, gating ignored
        ready_never = 0; ready_after = 0; link_hib = 0; feat_en = 0;
        exp_restore(1, 1, "R9");
        run(0, 1, 2'd0, 1, 0, "R9", 0);
        chk("R9", "flag unchanged", susp_flag, 1);

        // R10: invalid modes
        feat_en = 1; link_hib = 1;
        run(0, 1, 2'd2, 0, 1, "R10", 0);
        run(0, 1, 2'd3, 0, 1, "R10", 0);

        // R4: flag set but link not hibernating / feature off
        link_hib = 0;
        run(0, 1, 2'd1, 0, 0, "R4", 0);
        link_hib = 1; feat_en = 0;
        run(0, 1, 2'd1, 0, 0, "R4", 0);
        run(1, 0, 2'd1, 0, 0, "R2", 0);
        chk("R4", "flag still set", susp_flag, 1);

        // R12: simultaneous save and restore -> save only
        feat_en = 1; gen = 3;
        exp_save();
        run(1, 1, 2'd1, 1, 0, "R12", 0);
        chk("R12", "restore not performed", susp_flag, 1);
        gen = 4;

        // R5: restore brings back the newer snapshot
        exp_restore(0, 1, "R7");
        run(0, 1, 2'd1, 1, 0, "R5", 0);
        chk("R4", "flag cleared", susp_flag, 0);
        chk("R5", "queue drained", q.size(), 0);

        finish_up();
    end

endmodule